// File: doc/BRIEF.md
# Trigger Veto and Distribution Logic

This block takes four asynchronous trigger lines and four asynchronous activity (background) lines and decides which trigger starts an event. Each line has its own enable bit. When an enabled activity line rises, a veto window of programmable length opens, and no trigger is accepted while it is open. This keeps events free of pile-up. If an activity edge and a trigger edge fall in the same cycle, the trigger is rejected.

An accepted trigger latches the logic. No further trigger is taken until software writes the clear command. While the logic is latched, every enabled activity edge is recorded in a status field that is read out with the event. The accepted trigger leaves the block at once as a one-cycle pulse on all backplane fan-out lines. A copy, delayed by a programmable number of cycles, drives sixteen external lines. A 32-bit count of accepted triggers can be read through the register port and has its own clear command.

The register port is a plain write strobe, an address and a write word, with combinational read data.

Top module: `trig_gate_top`

## Requirements
- R1: After reset, all fan-out and external outputs are low. All registers read zero: every enable is off, the veto length is 0, the delay is 0, the status word is 0 and the count is 0.
- R2: Address 0 holds the enables. Bits [3:0] enable trigger lines 0..3 and bits [11:8] enable activity lines 0..3. A trigger whose enable bit is clear is never accepted. An activity line whose enable bit is clear opens no veto and is not recorded.
- R3: The veto length N is held at address 1, bits [15:0]. A trigger edge K cycles after an enabled activity edge is accepted only if K > N. An activity edge in the same cycle as a trigger edge (K = 0) always rejects that trigger.
- R4: Once a trigger is accepted, later trigger edges produce no output and leave the count unchanged. This lasts until bit 0 is written as 1 at address 3, which clears the latch.
- R5: An accepted trigger gives a single-cycle high pulse on every fan-out line. The pulse is high during the cycle after the third rising clock edge that follows the input's rise.
- R6: The external lines pulse together, one cycle long, d cycles after the fan-out pulse. The delay d (0..15) is held at address 2, bits [3:0].
- R7: The status word is at address 4. Bit 0 is the latch, bits [11:8] give the enabled trigger lines that caused acceptance, and bits [19:16] accumulate enabled activity lines that rose while latched. The clear command sets all of these to zero.
- R8: Address 5 holds the number of accepted triggers. It increments by one for each acceptance. Writing bit 1 as 1 at address 3 clears it and leaves the latch untouched.
- R9: Addresses 0, 1 and 2 read back the value last written, limited to their defined fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 4 | Asynchronous trigger lines |
| actIn | input | 4 | Asynchronous activity lines |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| fanOut | output | 8 | Immediate backplane copies of the accepted trigger |
| extOut | output | 16 | Delayed external copies of the accepted trigger |

## Verification
The hardest cases to reach are at the edges of the veto window, where a trigger must arrive exactly N cycles or N+1 cycles after an activity edge. Both lines pass through the same synchronizer depth. The stimulus therefore raises the activity line on one falling edge and the trigger line a chosen number of falling edges later, which sets the edge spacing K exactly. The vector table walks K across 0, N and N+1, and also includes a zero-length window.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;
  localparam int TRIG_N = 4;
  localparam int ACT_N  = 4;
  localparam int VETO_W = 16;
  localparam int CNT_W  = 32;

  // Register addresses
  localparam logic [2:0] A_ENABLE = 3'd0;
  localparam logic [2:0] A_VETO   = 3'd1;
  localparam logic [2:0] A_DELAY  = 3'd2;
  localparam logic [2:0] A_CMD    = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_COUNT  = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic              accept;
    logic              clrLatch;
    logic              clrCount;
    logic              latched;
    logic [TRIG_N-1:0] trigSrc;
    logic [ACT_N-1:0]  actSeen;
  } ctrl_strobe_t;

  // Configuration from datapath to control
  typedef struct packed {
    logic [TRIG_N-1:0] trigEn;
    logic [ACT_N-1:0]  actEn;
    logic [VETO_W-1:0] vetoLen;
  } gate_cfg_t;
endpackage

// File: rtl/trig_gate_ctrl.sv
module trig_gate_ctrl
  import trig_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [ACT_N-1:0]  actIn,
  input  logic         regWr,
  input  logic [2:0]   regAddr,
  input  logic [1:0]   cmdBits,
  input  gate_cfg_t    cfg,
  output ctrl_strobe_t stb
);
  localparam int SYNC_W = TRIG_N + ACT_N;

  logic [SYNC_W-1:0] s1, s2, s3;
  logic [SYNC_W-1:0] rise;
  logic [TRIG_N-1:0] trigEdge;
  logic [ACT_N-1:0]  actEdge;
  logic              actHit, vetoActive, accept, latched;
  logic [VETO_W-1:0] vetoCnt;
  logic              clrLatch, clrCount;

  // Two-stage synchronizer plus an edge stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {actIn, trigIn};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise     = s2 & ~s3;
  assign trigEdge = rise[TRIG_N-1:0];
  assign actEdge  = rise[SYNC_W-1:TRIG_N];

  assign actHit     = |(actEdge & cfg.actEn);
  assign vetoActive = actHit || (vetoCnt != '0);
  assign accept     = (|(trigEdge & cfg.trigEn)) && !vetoActive && !latched;

  assign clrLatch = regWr && (regAddr == A_CMD) && cmdBits[0];
  assign clrCount = regWr && (regAddr == A_CMD) && cmdBits[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vetoCnt <= '0;
    end else if (actHit) begin
      vetoCnt <= cfg.vetoLen;
    end else if (vetoCnt != '0) begin
      vetoCnt <= vetoCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         latched <= 1'b0;
    else if (accept)   latched <= 1'b1;
    else if (clrLatch) latched <= 1'b0;
  end

  always_comb begin
    stb.accept   = accept;
    stb.clrLatch = clrLatch;
    stb.clrCount = clrCount;
    stb.latched  = latched;
    stb.trigSrc  = trigEdge & cfg.trigEn;
    stb.actSeen  = actEdge & cfg.actEn;
  end

  // R4: the latch holds until the clear command
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !clrLatch) |=> latched);

  // R3: the window counts down by one unless an activity edge reloads it
  a_r3_veto_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (vetoCnt != '0 && !actHit) |=> (vetoCnt == $past(vetoCnt) - 1'b1));
endmodule

// File: rtl/trig_gate_dp.sv
module trig_gate_dp
  import trig_gate_pkg::*;
#(
  parameter int FAN_N = 8,
  parameter int EXT_N = 16,
  parameter int DLY_W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWr,
  input  logic [2:0]   regAddr,
  input  logic [31:0]  regWdata,
  output logic [31:0]  regRdata,
  input  ctrl_strobe_t stb,
  output gate_cfg_t    cfg,
  output logic [FAN_N-1:0] fanOut,
  output logic [EXT_N-1:0] extOut
);
  localparam int DLY_DEPTH = 1 << DLY_W;

  logic [TRIG_N-1:0]    trigEnQ, srcQ;
  logic [ACT_N-1:0]     actEnQ, actRec;
  logic [VETO_W-1:0]    vetoQ;
  logic [DLY_W-1:0]     dlyQ;
  logic [CNT_W-1:0]     cnt;
  logic [DLY_DEPTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigEnQ <= '0; actEnQ <= '0; vetoQ <= '0; dlyQ <= '0;
    end else if (regWr) begin
      case (regAddr)
        A_ENABLE: begin
          trigEnQ <= regWdata[TRIG_N-1:0];
          actEnQ  <= regWdata[8 +: ACT_N];
        end
        A_VETO:  vetoQ <= regWdata[VETO_W-1:0];
        A_DELAY: dlyQ  <= regWdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg.trigEn  = trigEnQ;
  assign cfg.actEn   = actEnQ;
  assign cfg.vetoLen = vetoQ;

  // Event record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0; actRec <= '0;
    end else if (stb.accept) begin
      srcQ <= stb.trigSrc; actRec <= '0;
    end else if (stb.clrLatch) begin
      srcQ <= '0; actRec <= '0;
    end else if (stb.latched) begin
      actRec <= actRec | stb.actSeen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (stb.clrCount) cnt <= '0;
    else if (stb.accept)   cnt <= cnt + 1'b1;
  end

  // Delay line: tap 0 is the fan-out copy
  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[DLY_DEPTH-2:0], stb.accept};
  end

  genvar gi;
  generate
    for (gi = 0; gi < FAN_N; gi++) begin : g_fan
      assign fanOut[gi] = pipe[0];
    end
    for (gi = 0; gi < EXT_N; gi++) begin : g_ext
      assign extOut[gi] = pipe[dlyQ];
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_ENABLE: begin
        regRdata[TRIG_N-1:0] = trigEnQ;
        regRdata[8 +: ACT_N] = actEnQ;
      end
      A_VETO:   regRdata[VETO_W-1:0] = vetoQ;
      A_DELAY:  regRdata[DLY_W-1:0]  = dlyQ;
      A_STATUS: begin
        regRdata[0]             = stb.latched;
        regRdata[8 +: TRIG_N]   = srcQ;
        regRdata[16 +: ACT_N]   = actRec;
      end
      A_COUNT:  regRdata[CNT_W-1:0] = cnt;
      default:  regRdata = '0;
    endcase
  end

  // R5: a fan-out pulse lasts exactly one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fanOut[0] |=> !fanOut[0]);

  // R8: each acceptance adds one to the count
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && !stb.clrCount) |=> (cnt == $past(cnt) + 1'b1));

  // R7: the clear command empties the post-trigger record
  a_r7_clear_record: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrLatch && !stb.accept) |=> (actRec == '0));
endmodule

// File: rtl/trig_gate_top.sv
module trig_gate_top
  import trig_gate_pkg::*;
#(
  parameter int FAN_N = 8,
  parameter int EXT_N = 16,
  parameter int DLY_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        trigIn,
  input  logic [3:0]        actIn,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [FAN_N-1:0]  fanOut,
  output logic [EXT_N-1:0]  extOut
);
  ctrl_strobe_t stb;
  gate_cfg_t    cfg;

  trig_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .actIn(actIn),
    .regWr(regWr), .regAddr(regAddr), .cmdBits(regWdata[1:0]),
    .cfg(cfg), .stb(stb)
  );

  trig_gate_dp #(.FAN_N(FAN_N), .EXT_N(EXT_N), .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .cfg(cfg),
    .fanOut(fanOut), .extOut(extOut)
  );
endmodule

// File: tb/test_trig_gate_top.sv
module test_trig_gate_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  trigIn = '0;
  logic [3:0]  actIn = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  fanOut;
  logic [15:0] extOut;

  int checks = 0;
  int failures = 0;
  int expCount = 0;

  trig_gate_top i_trig_gate_top (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .actIn(actIn),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fanOut(fanOut), .extOut(extOut)
  );

  always #2 clk = ~clk;

  // {trigEn, actEn, vetoLen, trigMask, actMask, lead, expAccept}
  typedef struct packed {
    logic [3:0] trigEn;
    logic [3:0] actEn;
    logic [7:0] vetoLen;
    logic [3:0] trigMask;
    logic [3:0] actMask;
    logic [7:0] lead;
    logic       expAcc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 4'hF, 8'd3, 4'b0001, 4'b0000, 8'd0, 1'b1}, // R2 plain accept
    '{4'b0001, 4'hF, 8'd3, 4'b0010, 4'b0000, 8'd0, 1'b0}, // R2 disabled trigger
    '{4'hF, 4'hF, 8'd3, 4'b0001, 4'b0001, 8'd0, 1'b0}, // R3 same cycle
    '{4'hF, 4'hF, 8'd3, 4'b0001, 4'b0010, 8'd2, 1'b0}, // R3 inside window
    '{4'hF, 4'hF, 8'd3, 4'b0100, 4'b0010, 8'd3, 1'b0}, // R3 K = N
    '{4'hF, 4'hF, 8'd3, 4'b0100, 4'b1000, 8'd4, 1'b1}, // R3 K = N+1
    '{4'hF, 4'b0000, 8'd3, 4'b0001, 4'b0001, 8'd0, 1'b1}, // R2 disabled activity
    '{4'hF, 4'hF, 8'd0, 4'b0010, 4'b0001, 8'd1, 1'b1}, // R3 zero window
    '{4'hF, 4'hF, 8'd3, 4'b1000, 4'b0000, 8'd0, 1'b1}  // R7 source field
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 fanOut", {24'd0, fanOut}, 32'd0);
    check("R1 extOut", {16'd0, extOut}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      regRead(a[2:0], rd);
      check("R1 register", rd, 32'd0);
    end

    // R9 readback
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, rd); check("R9 enables", rd, 32'h0000_0F0F);
    regWrite(3'd1, 32'h0001_1234);
    regRead(3'd1, rd); check("R9 veto", rd, 32'h0000_1234);
    regWrite(3'd2, 32'h0000_00F7);
    regRead(3'd2, rd); check("R9 delay", rd, 32'h0000_0007);
    regWrite(3'd2, 32'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      regWrite(3'd0, {20'd0, VECS[v].actEn, 4'd0, VECS[v].trigEn});
      regWrite(3'd1, {24'd0, VECS[v].vetoLen});
      regWrite(3'd3, 32'd1);
      idle(20);
      @(negedge clk);
      actIn = VECS[v].actMask;
      for (int k = 0; k < VECS[v].lead; k++) @(negedge clk);
      trigIn = VECS[v].trigMask;
      idle(2);
      actIn = '0; trigIn = '0;
      idle(6);
      regRead(3'd4, rd);
      check("R3 R2 accept decision", {31'd0, rd[0]}, {31'd0, VECS[v].expAcc});
      check("R7 source field", {28'd0, rd[11:8]},
            VECS[v].expAcc ? {28'd0, VECS[v].trigMask & VECS[v].trigEn} : 32'd0);
      if (VECS[v].expAcc) expCount++;
      regRead(3'd5, rd);
      check("R8 count", rd, expCount);
    end

    // R5 latency and width
    regWrite(3'd0, 32'h0000_0F0F);
    regWrite(3'd1, 32'd0);
    regWrite(3'd2, 32'd5);
    regWrite(3'd3, 32'd1);
    idle(4);
    @(negedge clk); trigIn = 4'b0001;
    @(negedge clk); check("R5 low after 1 edge", {24'd0, fanOut}, 32'd0);
    @(negedge clk); check("R5 low after 2 edges", {24'd0, fanOut}, 32'd0);
    trigIn = '0;
    @(negedge clk); check("R5 high after 3 edges", {24'd0, fanOut}, 32'h0000_00FF);
    check("R6 ext not yet", {16'd0, extOut}, 32'd0);
    @(negedge clk); check("R5 one cycle", {24'd0, fanOut}, 32'd0);
    expCount++;
    // R6: fan-out was seen after 3 edges; ext after 3+5 edges
    idle(3);
    check("R6 ext before d", {16'd0, extOut}, 32'd0);
    @(negedge clk); check("R6 ext at d", {16'd0, extOut}, 32'h0000_FFFF);
    @(negedge clk); check("R6 ext one cycle", {16'd0, extOut}, 32'd0);

    // R4 latched: second trigger ignored
    @(negedge clk); trigIn = 4'b0010;
    idle(2); trigIn = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4 no fanOut while latched", {24'd0, fanOut}, 32'd0);
    end
    regRead(3'd5, rd); check("R4 count unchanged", rd, expCount);

    // R7 post-trigger activity record
    @(negedge clk); actIn = 4'b0100;
    idle(2); actIn = '0;
    idle(4);
    regRead(3'd4, rd);
    check("R7 activity record", {28'd0, rd[19:16]}, 32'h4);
    check("R7 latch bit", {31'd0, rd[0]}, 32'd1);

    // R8 count clear leaves latch
    regWrite(3'd3, 32'd2);
    regRead(3'd5, rd); check("R8 count cleared", rd, 32'd0);
    regRead(3'd4, rd); check("R8 latch kept", {31'd0, rd[0]}, 32'd1);
    expCount = 0;

    // R7 / R4 clear
    regWrite(3'd3, 32'd1);
    regRead(3'd4, rd); check("R7 status cleared", rd, 32'd0);
    @(negedge clk); trigIn = 4'b0100;
    idle(2); trigIn = '0;
    idle(3);
    regRead(3'd5, rd); check("R4 accept after clear", rd, 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule